// File: doc/BRIEF.md
# Shared Sample RAM Arbiter with Reservation Tracking

This block lets a small audio engine and a host bus share one synchronous RAM that holds sample tables and control variables. The RAM is organised as halfwords: each address selects one 16-bit word, and neighbouring words differ by one in address. The engine issues plain loads and stores, plus a reserving load and a guarded store. The host issues reads and writes through a valid/ready handshake and may do so at any time, whether or not the engine is running.

Engine accesses always take the single RAM port. A host request that arrives while the engine is using the port sees ready low and waits until the port is free. Read data for either side is presented one cycle after the access is taken.

The block holds one reservation: a flag and an address. A reserving load sets the flag and records its address. A host write to the recorded address clears the flag, and any guarded store also clears it. A guarded store writes only while the flag is set. When the flag is clear, the store is dropped and the engine is not told. This lets the engine do a read-modify-write on a control variable while the host updates that same variable. A host update that lands in between cancels the engine's write-back.

Top module: `sample_ram_arbiter`

## Requirements
- R1: After reset, host_ready is high while core_req is low, host_rvalid is low and no reservation is held. A guarded store issued before any reserving load leaves memory unchanged.
- R2: A core load (core_op 0) or reserving load (core_op 2) returns the addressed word on core_rdata in the cycle after the request.
- R3: While core_req is high, host_ready is low. A held host request is taken in the first cycle in which core_req is low.
- R4: A host read taken while host_valid and host_ready are both high raises host_rvalid for exactly the next cycle, with the word on host_rdata. A host write taken the same way (host_we 1) updates the addressed word.
- R5: A core store (core_op 1) always writes core_wdata to core_addr.
- R6: A reserving load followed by a guarded store (core_op 3) to the same address, with no host write to that address in between, writes the store data.
- R7: A host write to the reserved address, taken between a reserving load and a guarded store, makes that guarded store leave memory unchanged.
- R8: A host write to any address other than the reserved one leaves the reservation in place, so a following guarded store still writes.
- R9: Every guarded store clears the reservation. A second guarded store with no new reserving load leaves memory unchanged.
- R10: A newer reserving load moves the reservation to its own address. Host writes to the previous address then no longer cancel it.
- R11: A host write held off by a reserving load to the same address is applied after that load and cancels the reservation. If a clear and a reserving load fall in the same cycle, the reserving load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Engine access request this cycle |
| core_op | input | 2 | 0 load, 1 store, 2 reserving load, 3 guarded store |
| core_addr | input | ADDR_W | Engine halfword address |
| core_wdata | input | DATA_W | Engine store data |
| core_rdata | output | DATA_W | Engine load data, one cycle after the request |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request can be taken this cycle |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host halfword address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data |
| host_rvalid | output | 1 | host_rdata valid this cycle |

## Verification
The hardest case to reach is a host write to the reserved address that collides with the reserving load itself. Core priority means the write is never taken in the same cycle as the load. The bench therefore raises a host write to that address in the same cycle as the reserving load and holds it through the stall. It then issues a guarded store and reads the word back, to show that the late write cancelled the reservation. The remaining cases come from separate directed tasks: a reservation that a write to another address leaves intact, a moved reservation, and a second guarded store. Each task observes the result only through memory contents read back over the host port.

// File: rtl/sample_ram_arbiter_pkg.sv
package sample_ram_arbiter_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_STORE = 2'd1,
      OP_LINK  = 2'd2,
      OP_COND  = 2'd3
   } core_op_e;

   function automatic logic op_is_read(input core_op_e op);
      return (op == OP_LOAD) || (op == OP_LINK);
   endfunction
endpackage

// File: rtl/sra_sync_ram.sv
module sra_sync_ram #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end
endmodule

// File: rtl/sra_excl_monitor.sv
module sra_excl_monitor #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_set,
   input  logic [ADDR_W-1:0] link_addr,
   input  logic              cond_exec,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_wr_addr,
   output logic              resv_valid,
   output logic [ADDR_W-1:0] resv_addr
);
   logic host_hit;
   logic flag_nxt;

   assign host_hit = host_wr && (host_wr_addr == resv_addr);

   always_comb begin
      flag_nxt = resv_valid;
      if (host_hit || cond_exec) flag_nxt = 1'b0;
      if (link_set)              flag_nxt = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resv_valid <= 1'b0;
         resv_addr  <= '0;
      end else begin
         resv_valid <= flag_nxt;
         if (link_set) resv_addr <= link_addr;
      end
   end
endmodule

// File: rtl/sra_port_mux.sv
module sra_port_mux
   import sample_ram_arbiter_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              core_req,
   input  core_op_e          core_op,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic [DATA_W-1:0] core_wdata,
   input  logic              resv_valid,
   input  logic              host_valid,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_ready,
   output logic              host_rd_take,
   output logic              host_wr_take,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);
   logic core_writes;

   assign host_ready   = !core_req;
   assign host_rd_take = host_valid && host_ready && !host_we;
   assign host_wr_take = host_valid && host_ready &&  host_we;

   always_comb begin
      core_writes = 1'b0;
      unique case (core_op)
         OP_STORE: core_writes = 1'b1;
         OP_COND:  core_writes = resv_valid;
         default:  core_writes = 1'b0;
      endcase
   end

   always_comb begin
      if (core_req) begin
         mem_en    = op_is_read(core_op) || core_writes;
         mem_we    = core_writes;
         mem_addr  = core_addr;
         mem_wdata = core_wdata;
      end else begin
         mem_en    = host_rd_take || host_wr_take;
         mem_we    = host_wr_take;
         mem_addr  = host_addr;
         mem_wdata = host_wdata;
      end
   end
endmodule

// File: rtl/sample_ram_arbiter.sv
module sample_ram_arbiter
   import sample_ram_arbiter_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_req,
   input  logic [1:0]        core_op,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic [DATA_W-1:0] core_wdata,
   output logic [DATA_W-1:0] core_rdata,
   input  logic              host_valid,
   output logic              host_ready,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rvalid
);
   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("sample_ram_arbiter: ADDR_W must be 1..12");
      end
      if (DATA_W < 2 || DATA_W > 64) begin : g_bad_data
         $error("sample_ram_arbiter: DATA_W must be 2..64");
      end
   endgenerate

   core_op_e          op;
   logic              resv_valid;
   logic [ADDR_W-1:0] resv_addr;
   logic              host_rd_take;
   logic              host_wr_take;
   logic              mem_en;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata;
   logic [DATA_W-1:0] mem_rdata;
   logic              link_set;
   logic              cond_exec;

   assign op        = core_op_e'(core_op);
   assign link_set  = core_req && (op == OP_LINK);
   assign cond_exec = core_req && (op == OP_COND);

   sra_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
      .core_req     (core_req),
      .core_op      (op),
      .core_addr    (core_addr),
      .core_wdata   (core_wdata),
      .resv_valid   (resv_valid),
      .host_valid   (host_valid),
      .host_we      (host_we),
      .host_addr    (host_addr),
      .host_wdata   (host_wdata),
      .host_ready   (host_ready),
      .host_rd_take (host_rd_take),
      .host_wr_take (host_wr_take),
      .mem_en       (mem_en),
      .mem_we       (mem_we),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata)
   );

   sra_excl_monitor #(.ADDR_W(ADDR_W)) u_mon (
      .clk          (clk),
      .rst_n        (rst_n),
      .link_set     (link_set),
      .link_addr    (core_addr),
      .cond_exec    (cond_exec),
      .host_wr      (host_wr_take),
      .host_wr_addr (host_addr),
      .resv_valid   (resv_valid),
      .resv_addr    (resv_addr)
   );

   sra_sync_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk   (clk),
      .en    (mem_en),
      .we    (mem_we),
      .addr  (mem_addr),
      .wdata (mem_wdata),
      .rdata (mem_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) host_rvalid <= 1'b0;
      else        host_rvalid <= host_rd_take;
   end

   assign core_rdata = mem_rdata;
   assign host_rdata = mem_rdata;
endmodule

// File: rtl/sample_ram_arbiter_checker.sv
module sample_ram_arbiter_checker #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              core_req,
   input logic [1:0]        core_op,
   input logic              host_valid,
   input logic              host_ready,
   input logic              host_we,
   input logic [ADDR_W-1:0] host_addr,
   input logic              host_rvalid,
   input logic              resv_valid,
   input logic [ADDR_W-1:0] resv_addr
);
   AST_HOST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      core_req |-> !host_ready);                                                  // R3
   AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !core_req |-> host_ready);                                                  // R3
   AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && host_ready && !host_we) |=> host_rvalid);                    // R4
   AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_valid && host_ready && !host_we) |=> !host_rvalid);                  // R4
   AST_LINK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (core_req && core_op == 2'd2) |=> resv_valid);                              // R11
   AST_COND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (core_req && core_op == 2'd3) |=> !resv_valid);                             // R9
   AST_OTHER_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (resv_valid && !core_req && host_valid && host_we && host_addr != resv_addr)
      |=> resv_valid);                                                            // R8
   AST_HIT_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (resv_valid && !core_req && host_valid && host_we && host_addr == resv_addr)
      |=> !resv_valid);                                                           // R7
endmodule

bind sample_ram_arbiter sample_ram_arbiter_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .core_req    (core_req),
   .core_op     (core_op),
   .host_valid  (host_valid),
   .host_ready  (host_ready),
   .host_we     (host_we),
   .host_addr   (host_addr),
   .host_rvalid (host_rvalid),
   .resv_valid  (resv_valid),
   .resv_addr   (resv_addr)
);

// File: tb/sample_ram_arbiter_bench.sv
module sample_ram_arbiter_bench;
   localparam int AW = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          core_req = 1'b0;
   logic [1:0]    core_op = 2'd0;
   logic [AW-1:0] core_addr = '0;
   logic [DW-1:0] core_wdata = '0;
   logic [DW-1:0] core_rdata;
   logic          host_valid = 1'b0;
   logic          host_ready;
   logic          host_we = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata;
   logic          host_rvalid;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sample_ram_arbiter #(.ADDR_W(AW), .DATA_W(DW)) u_sample_ram_arbiter (.*);

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic core_do(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      core_req = 1'b1; core_op = op; core_addr = a; core_wdata = d;
      @(negedge clk);
      core_req = 1'b0;
   endtask

   task automatic host_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      host_valid = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
      while (!host_ready) @(negedge clk);
      @(negedge clk);
      host_valid = 1'b0; host_we = 1'b0;
   endtask

   task automatic host_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      host_valid = 1'b1; host_we = 1'b0; host_addr = a;
      while (!host_ready) @(negedge clk);
      @(negedge clk);
      host_valid = 1'b0;
      check("R4 rvalid", {15'd0, host_rvalid}, 16'd1);
      d = host_rdata;
      @(negedge clk);
      check("R4 rvalid drops", {15'd0, host_rvalid}, 16'd0);
   endtask

   task automatic expect_mem(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      logic [DW-1:0] v;
      host_rd(a, v);
      check(req, v, exp);
   endtask

   task automatic t_reset;
      check("R1 ready after reset", {15'd0, host_ready}, 16'd1);
      check("R1 rvalid after reset", {15'd0, host_rvalid}, 16'd0);
      host_wr(8'h10, 16'h1111);
      core_do(2'd3, 8'h10, 16'hdead);
      expect_mem("R1 guarded store before any link dropped", 8'h10, 16'h1111);
   endtask

   task automatic t_basic;
      host_wr(8'h20, 16'ha5a5);
      host_wr(8'h21, 16'h5a5a);
      expect_mem("R4 host write/read", 8'h20, 16'ha5a5);
      expect_mem("R4 adjacent halfword", 8'h21, 16'h5a5a);
      core_do(2'd0, 8'h21, 16'h0);
      check("R2 core load data", core_rdata, 16'h5a5a);
      core_do(2'd1, 8'h22, 16'h1234);
      expect_mem("R5 core store", 8'h22, 16'h1234);
      core_do(2'd2, 8'h20, 16'h0);
      check("R2 reserving load data", core_rdata, 16'ha5a5);
   endtask

   task automatic t_stall;
      logic [DW-1:0] v;
      host_wr(8'h30, 16'hbeef);
      @(negedge clk);
      core_req = 1'b1; core_op = 2'd1; core_addr = 8'h31; core_wdata = 16'h0101;
      host_valid = 1'b1; host_we = 1'b0; host_addr = 8'h30;
      @(negedge clk);
      check("R3 ready low under core", {15'd0, host_ready}, 16'd0);
      check("R3 no rvalid while stalled", {15'd0, host_rvalid}, 16'd0);
      core_addr = 8'h32; core_wdata = 16'h0202;
      @(negedge clk);
      check("R3 still stalled", {15'd0, host_ready}, 16'd0);
      core_req = 1'b0;
      #1;
      check("R3 ready when core idle", {15'd0, host_ready}, 16'd1);
      @(negedge clk);
      host_valid = 1'b0;
      check("R3 held read taken", {15'd0, host_rvalid}, 16'd1);
      v = host_rdata;
      check("R3 held read data", v, 16'hbeef);
      expect_mem("R5 store during stall 1", 8'h31, 16'h0101);
      expect_mem("R5 store during stall 2", 8'h32, 16'h0202);
   endtask

   task automatic t_link_ok;
      host_wr(8'h40, 16'h0007);
      core_do(2'd2, 8'h40, 16'h0);
      core_do(2'd3, 8'h40, 16'h0006);
      expect_mem("R6 guarded store lands", 8'h40, 16'h0006);
      core_do(2'd3, 8'h40, 16'h0005);
      expect_mem("R9 second guarded store dropped", 8'h40, 16'h0006);
   endtask

   task automatic t_link_hit;
      host_wr(8'h50, 16'h0010);
      core_do(2'd2, 8'h50, 16'h0);
      host_wr(8'h50, 16'h0099);
      core_do(2'd3, 8'h50, 16'h000f);
      expect_mem("R7 host write cancels store", 8'h50, 16'h0099);
   endtask

   task automatic t_link_other;
      host_wr(8'h60, 16'h0020);
      core_do(2'd2, 8'h60, 16'h0);
      host_wr(8'h61, 16'h7777);
      core_do(2'd3, 8'h60, 16'h001f);
      expect_mem("R8 other-address write keeps reservation", 8'h60, 16'h001f);
   endtask

   task automatic t_link_move;
      host_wr(8'h70, 16'h0001);
      host_wr(8'h71, 16'h0002);
      core_do(2'd2, 8'h70, 16'h0);
      core_do(2'd2, 8'h71, 16'h0);
      host_wr(8'h70, 16'h0003);
      core_do(2'd3, 8'h71, 16'h00aa);
      expect_mem("R10 reservation moved to newer load", 8'h71, 16'h00aa);
   endtask

   task automatic t_collide;
      host_wr(8'h80, 16'h0100);
      @(negedge clk);
      core_req = 1'b1; core_op = 2'd2; core_addr = 8'h80;
      host_valid = 1'b1; host_we = 1'b1; host_addr = 8'h80; host_wdata = 16'h0200;
      @(negedge clk);
      core_req = 1'b0;
      check("R11 load sees old data", core_rdata, 16'h0100);
      @(negedge clk);
      host_valid = 1'b0; host_we = 1'b0;
      core_do(2'd3, 8'h80, 16'h00ff);
      expect_mem("R11 late host write cancels", 8'h80, 16'h0200);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_stall();
      t_link_ok();
      t_link_hit();
      t_link_other();
      t_link_move();
      t_collide();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule